// File: doc/BRIEF.md
# Console Control-Character Reset Detector

This block listens to the receive-data wire of an embedded processor's serial console and turns a short run of control characters into a system reset request. An operator who can reach the console from far away can force the processor to restart by typing three control characters in a row, even when the software on the processor has stopped responding. The block only listens to the wire and never drives it.

Inside, a clock divider produces an oversampling tick at sixteen times the bit rate. A receive-only UART recovers 8N1 frames: eight data bits, least significant bit first, with one start bit, one stop bit and no parity. A matcher counts how many qualifying characters have arrived back to back. When the count reaches three, the matcher drives a reset pulse of fixed length. Every correctly framed byte also appears on a one-cycle debug strobe together with its value.

Top module: `console_reset_detect`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `reset_req` and `byte_strobe` are low and the match count is empty, so a single qualifying character sent after reset does not trigger.
- R2: A bit lasts 16 × `TICK_DIV` clock cycles. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each such frame raises `byte_strobe` for exactly one cycle, and `byte_value` then carries the eight bits. This holds for all 256 byte values.
- R3: A low level on the line that ends before the 8th oversample tick after its falling edge is dropped as noise and produces no strobe.
- R4: A line held high produces no strobe. A line held low (a break) produces no strobe and no further frames until it returns high and falls again.
- R5: `reset_req` rises in the cycle after the strobe of the third consecutive character from the set 0x18, 0x19 and 0x1A. The three may be any mix of these values.
- R6: A correctly framed byte outside that set clears the consecutive count to zero.
- R7: A frame whose stop bit is sampled low produces no strobe and clears the consecutive count to zero.
- R8: Once raised, `reset_req` stays high for exactly `PULSE_CYCLES` clock cycles and then falls.
- R9: The count clears when a pulse starts. A qualifying character that arrives during the pulse neither lengthens the pulse nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_pin | input | 1 | Asynchronous serial receive line, high when idle |
| reset_req | output | 1 | System reset request pulse |
| byte_strobe | output | 1 | One-cycle strobe for each correctly framed byte |
| byte_value | output | 8 | Value of the byte flagged by `byte_strobe` |

## Verification
The receiver's byte strobe and the matcher's pulse timer can act in the same cycle. This happens when a new qualifying character completes while `reset_req` is already high. The bench provokes it by sending a fourth matching character right after a triggering triple, at a point where the pulse still has cycles left. The bench then counts the rising edges and the high cycles of `reset_req`, and a correct design shows one rising edge and exactly `PULSE_CYCLES` high cycles. A full sweep of all 256 byte values also passes through the run 0x18, 0x19, 0x1A. That sweep must produce exactly one pulse, while every byte strobed during the pulse must still be received correctly.

// File: rtl/crd_pkg.sv
package crd_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    localparam logic [7:0] CHAR_CTRL_X = 8'h18;
    localparam logic [7:0] CHAR_CTRL_Y = 8'h19;
    localparam logic [7:0] CHAR_CTRL_Z = 8'h1A;

    // True when a byte belongs to the trigger set (any mix counts)
    function automatic logic is_trigger_char(input logic [7:0] b);
        return (b == CHAR_CTRL_X) || (b == CHAR_CTRL_Y) || (b == CHAR_CTRL_Z);
    endfunction

endpackage

// File: rtl/crd_tick_gen.sv
module crd_tick_gen #(
    parameter int TICK_DIV = 651
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_s;

    tick_s tick_d, tick_q;

    always_comb begin
        tick_d      = tick_q;
        tick_d.tick = (tick_q.cnt == LAST);
        if (tick_q.cnt == LAST) begin
            tick_d.cnt = '0;
        end else begin
            tick_d.cnt = tick_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q.tick;

endmodule

// File: rtl/crd_uart_rx.sv
module crd_uart_rx
    import crd_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_pin,
    input  logic       tick,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       frame_err
);
    localparam int OW = $clog2(OVERSAMPLE);
    localparam logic [OW-1:0] MID_TICK  = OW'(OVERSAMPLE / 2 - 1);
    localparam logic [OW-1:0] FULL_TICK = OW'(OVERSAMPLE - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        rx_state_e              state;
        logic [OW-1:0]          os_cnt;
        logic [2:0]             bit_idx;
        logic [7:0]             shreg;
        logic [7:0]             data;
        logic                   vld;
        logic                   ferr;
    } rx_s;

    rx_s rx_d, rx_q;
    logic line;

    assign line = rx_q.sync[SYNC_STAGES-1];

    always_comb begin
        rx_d      = rx_q;
        rx_d.vld  = 1'b0;
        rx_d.ferr = 1'b0;
        rx_d.sync = {rx_q.sync[SYNC_STAGES-2:0], rx_pin};
        rx_d.prev = line;

        unique case (rx_q.state)
            RX_IDLE: begin
                if (rx_q.prev && !line) begin
                    rx_d.state  = RX_START;
                    rx_d.os_cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (rx_q.os_cnt == MID_TICK) begin
                        rx_d.os_cnt  = '0;
                        rx_d.bit_idx = '0;
                        rx_d.state   = line ? RX_IDLE : RX_DATA;
                    end else begin
                        rx_d.os_cnt = rx_q.os_cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (rx_q.os_cnt == FULL_TICK) begin
                        rx_d.os_cnt = '0;
                        rx_d.shreg  = {line, rx_q.shreg[7:1]};
                        if (rx_q.bit_idx == 3'd7) begin
                            rx_d.state = RX_STOP;
                        end else begin
                            rx_d.bit_idx = rx_q.bit_idx + 1'b1;
                        end
                    end else begin
                        rx_d.os_cnt = rx_q.os_cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (rx_q.os_cnt == FULL_TICK) begin
                        rx_d.state = RX_IDLE;
                        if (line) begin
                            rx_d.vld  = 1'b1;
                            rx_d.data = rx_q.shreg;
                        end else begin
                            rx_d.ferr = 1'b1;
                        end
                    end else begin
                        rx_d.os_cnt = rx_q.os_cnt + 1'b1;
                    end
                end
            end
            default: rx_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q         <= '0;
            rx_q.sync    <= '1;
            rx_q.prev    <= 1'b1;
            rx_q.state   <= RX_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld  = rx_q.vld;
    assign byte_data = rx_q.data;
    assign frame_err = rx_q.ferr;

endmodule

// File: rtl/crd_seq_match.sv
module crd_seq_match
    import crd_pkg::*;
#(
    parameter int MATCH_LEN    = 3,
    parameter int PULSE_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       frame_err,
    output logic       reset_req
);
    localparam int CW = $clog2(MATCH_LEN + 1);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LAST_MATCH = CW'(MATCH_LEN - 1);
    localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pulse;
    } match_s;

    match_s m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (m_q.pulse != '0) begin
            m_d.pulse = m_q.pulse - 1'b1;
        end
        if (frame_err) begin
            m_d.cnt = '0;
        end else if (byte_vld) begin
            if (is_trigger_char(byte_data)) begin
                if (m_q.cnt == LAST_MATCH) begin
                    m_d.cnt = '0;
                    if (m_q.pulse == '0) begin
                        m_d.pulse = PULSE_LOAD;
                    end
                end else begin
                    m_d.cnt = m_q.cnt + 1'b1;
                end
            end else begin
                m_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign reset_req = (m_q.pulse != '0);

endmodule

// File: rtl/console_reset_detect.sv
module console_reset_detect #(
    parameter int TICK_DIV     = 651,
    parameter int OVERSAMPLE   = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int MATCH_LEN    = 3,
    parameter int PULSE_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_pin,
    output logic       reset_req,
    output logic       byte_strobe,
    output logic [7:0] byte_value
);
    logic       tick;
    logic       rx_vld;
    logic [7:0] rx_data;
    logic       rx_ferr;

    crd_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    crd_uart_rx #(
        .OVERSAMPLE (OVERSAMPLE),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_pin   (rx_pin),
        .tick     (tick),
        .byte_vld (rx_vld),
        .byte_data(rx_data),
        .frame_err(rx_ferr)
    );

    crd_seq_match #(
        .MATCH_LEN   (MATCH_LEN),
        .PULSE_CYCLES(PULSE_CYCLES)
    ) u_match (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (rx_vld),
        .byte_data(rx_data),
        .frame_err(rx_ferr),
        .reset_req(reset_req)
    );

    assign byte_strobe = rx_vld;
    assign byte_value  = rx_data;

endmodule

// File: rtl/crd_checker.sv
module crd_checker
    import crd_pkg::*;
#(
    parameter int PULSE_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       reset_req,
    input logic       byte_strobe,
    input logic [7:0] byte_value
);
    logic [31:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (reset_req) begin
            hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!reset_req && !byte_strobe)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        byte_strobe |=> !byte_strobe); // R2

    AST_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req) |-> ($past(byte_strobe) && is_trigger_char($past(byte_value)))); // R5

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_req) |-> (hi_run == 32'(PULSE_CYCLES))); // R8

    AST_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (hi_run < 32'(PULSE_CYCLES))); // R9

endmodule

bind console_reset_detect crd_checker #(
    .PULSE_CYCLES(PULSE_CYCLES)
) u_crd_checker (
    .clk        (clk),
    .rst        (rst),
    .reset_req  (reset_req),
    .byte_strobe(byte_strobe),
    .byte_value (byte_value)
);

// File: tb/console_reset_detect_tb.sv
module console_reset_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int PULSE      = 600;
    localparam int BIT_CYC    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_pin = 1'b1;
    logic       reset_req;
    logic       byte_strobe;
    logic [7:0] byte_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] got [0:511];
    int got_n = 0;
    int rises = 0;
    int hi_total = 0;
    logic rr_prev = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    console_reset_detect #(
        .TICK_DIV    (TICK_DIV),
        .PULSE_CYCLES(PULSE)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rx_pin     (rx_pin),
        .reset_req  (reset_req),
        .byte_strobe(byte_strobe),
        .byte_value (byte_value)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_strobe) begin
                if (got_n < 512) got[got_n] = byte_value;
                got_n++;
            end
            if (reset_req) hi_total++;
            if (reset_req && !rr_prev) rises++;
            rr_prev = reset_req;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drive(input logic v, input int n);
        rx_pin <= v;
        wait_cyc(n);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        drive(1'b0, BIT_CYC);
        for (int i = 0; i < 8; i++) drive(b[i], BIT_CYC);
        drive(good_stop, BIT_CYC);
        drive(1'b1, BIT_CYC);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        wait_cyc(190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        int g0, r0, h0;
        wait_cyc(5);
        check(reset_req === 1'b0, "R1 reset_req during reset", reset_req, 0);
        check(byte_strobe === 1'b0, "R1 strobe during reset", byte_strobe, 0);
        @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        check(reset_req === 1'b0 && byte_strobe === 1'b0, "R1 outputs after reset", reset_req, 0);

        // R1: single qualifying char after reset must not trigger
        r0 = rises;
        send_byte(8'h1A, 1'b1);
        wait_cyc(BIT_CYC);
        check(rises == r0, "R1 empty count after reset", rises - r0, 0);

        // R4: idle high
        g0 = got_n;
        wait_cyc(1500);
        check(got_n == g0, "R4 idle high no strobe", got_n - g0, 0);

        // R3: short glitch
        g0 = got_n;
        drive(1'b0, 6);
        drive(1'b1, 20 * BIT_CYC);
        check(got_n == g0, "R3 glitch rejected", got_n - g0, 0);

        // R4: break condition
        g0 = got_n;
        r0 = rises;
        drive(1'b0, 3000);
        drive(1'b1, 2 * BIT_CYC);
        check(got_n == g0, "R4 break no strobe", got_n - g0, 0);
        // R7: the break frame also cleared the count
        send_byte(8'h18, 1'b1);
        send_byte(8'h19, 1'b1);
        wait_cyc(BIT_CYC);
        check(rises == r0, "R7 break clears nothing triggers", rises - r0, 0);
        send_byte(8'h00, 1'b1);

        // R2 and R5: exhaustive sweep, run 0x18,0x19,0x1A triggers once
        g0 = got_n;
        r0 = rises;
        h0 = hi_total;
        for (int v = 0; v < 256; v++) send_byte(8'(v), 1'b1);
        wait_cyc(PULSE + 100);
        check(got_n - g0 == 256, "R2 sweep strobe count", got_n - g0, 256);
        for (int v = 0; v < 256; v++) begin
            if (g0 + v < 512)
                check(got[g0 + v] == 8'(v), "R2 sweep byte value", int'(got[g0 + v]), v);
        end
        check(rises - r0 == 1, "R5 sweep single trigger", rises - r0, 1);
        check(hi_total - h0 == PULSE, "R8 pulse width", hi_total - h0, PULSE);

        // R5: mixed order Y,X,Z
        r0 = rises;
        send_byte(8'h19, 1'b1);
        send_byte(8'h18, 1'b1);
        send_byte(8'h1A, 1'b1);
        wait_cyc(PULSE + 100);
        check(rises - r0 == 1, "R5 mixed Y X Z triggers", rises - r0, 1);

        // R6: non-member breaks the run
        r0 = rises;
        send_byte(8'h18, 1'b1);
        send_byte(8'h18, 1'b1);
        send_byte(8'h41, 1'b1);
        send_byte(8'h1A, 1'b1);
        wait_cyc(BIT_CYC);
        check(rises == r0, "R6 other byte clears count", rises - r0, 0);
        send_byte(8'h1A, 1'b1);
        send_byte(8'h1A, 1'b1);
        wait_cyc(PULSE + 100);
        check(rises - r0 == 1, "R6 fresh run after clear", rises - r0, 1);

        // R7: framing error breaks the run and is not strobed
        r0 = rises;
        send_byte(8'h55, 1'b1);
        g0 = got_n;
        send_byte(8'h18, 1'b1);
        send_byte(8'h19, 1'b0);
        send_byte(8'h1A, 1'b1);
        wait_cyc(BIT_CYC);
        check(got_n - g0 == 2, "R7 bad frame not strobed", got_n - g0, 2);
        check(rises == r0, "R7 framing error clears count", rises - r0, 0);

        // R9: fourth matching byte inside the pulse
        send_byte(8'h55, 1'b1);
        r0 = rises;
        h0 = hi_total;
        send_byte(8'h18, 1'b1);
        send_byte(8'h19, 1'b1);
        send_byte(8'h1A, 1'b1);
        send_byte(8'h18, 1'b1);
        wait_cyc(PULSE + 100);
        check(rises - r0 == 1, "R9 fourth byte no retrigger", rises - r0, 1);
        check(hi_total - h0 == PULSE, "R9 fourth byte no extension", hi_total - h0, PULSE);

        if (!done) begin
            done = 1'b1;
            report();
            $finish;
        end
    end

endmodule